// File: doc/BRIEF.md
# Eight-Channel Auto-Reload DMA Address Controller

This controller supplies memory addresses for direct transfers between peripherals and data memory. It does not carry data. Each of eight channels holds a base address, a buffer length, a running offset and a mode bit. The mode is either one-shot or circular. A request on a channel line makes the controller ask the CPU for the bus. Once the CPU acknowledges release, the controller drives the channel's current address for one cycle. In that same cycle it strobes a separate peripheral data controller, which places the byte on the data bus.

After the transfer, the controller returns the bus and moves the channel's offset forward. When a one-shot channel has used its whole length, it marks itself done and goes quiet until software programs it again. A circular channel instead rewinds to its base and goes on serving requests. Software programs a channel with a single write. A write that arrives while a transfer is under way is held back until the bus has been returned.

Top module: `dma_addr_ctrl`

## Requirements
- R1: After reset, `bus_req`, `addr_oe` and `dev_strobe` are low and every bit of `done` is 1, so requests on unprogrammed channels raise no bus request.
- R2: A configuration write loads base, length and mode for channel `cfg_ch` and sets its offset to 0. It clears that channel's done bit when the length is non-zero and sets it when the length is 0.
- R3: An active request on a channel whose done bit is 0 raises `bus_req` on the next clock. The address is driven only in the cycle after `bus_ack` is sampled high while requesting.
- R4: The driven address is the channel's base plus its offset, modulo 2^14. The offset starts at 0 and grows by 1 after each transfer.
- R5: `addr_oe`, `dev_strobe` and `dev_sel` (the channel number, 0..7) are high or valid for exactly one cycle per grant. `bus_req` is low in the following cycle, and the controller raises no new request until `bus_ack` has gone low.
- R6: One-shot mode (`cfg_circ`=0): when the offset would reach the length, the done bit is set and further requests on that channel are ignored until it is reprogrammed.
- R7: Circular mode (`cfg_circ`=1): when the offset would reach the length, it returns to 0, the base address is used again, and the done bit stays 0.
- R8: When several channels request at once, the lowest channel number wins. Exactly one transfer is made per grant.
- R9: A configuration write while the controller is not idle takes effect only after it returns to idle. The transfer in progress uses the old settings, and a later held write replaces an earlier one.
- R10: `done` reports each channel's done bit, with bit i belonging to channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel being programmed |
| cfg_base | input | 14 | Base address |
| cfg_len | input | 8 | Buffer length in transfers |
| cfg_circ | input | 1 | 1 = circular, 0 = one-shot |
| chan_req | input | 8 | Per-channel transfer requests |
| bus_ack | input | 1 | CPU has released the bus |
| bus_req | output | 1 | Bus request to the CPU |
| addr_oe | output | 1 | Address bus driven |
| mem_addr | output | 14 | Memory address |
| dev_strobe | output | 1 | Tells the peripheral controller to put its byte on the data bus |
| dev_sel | output | 3 | Channel being served |
| done | output | 8 | Per-channel done flags |

## Verification
Single-channel requests on three channels show that each offset advances from its own base, including a base near the top of memory where the address wraps through zero. Overlapping request masks show that the lowest channel is chosen and that one grant moves only one channel. Running one-shot and circular channels past their lengths tells exhaustion apart from reload. A configuration write issued mid-grant shows whether the old settings were kept for that transfer and the new ones applied afterwards.

// File: rtl/dma_addr_ctrl.sv
module dma_addr_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = 14,
  parameter int LW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_ch,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_circ,
  input  logic [NCH-1:0] chan_req,
  input  logic          bus_ack,
  output logic          bus_req,
  output logic          addr_oe,
  output logic [AW-1:0] mem_addr,
  output logic          dev_strobe,
  output logic [CW-1:0] dev_sel,
  output logic [NCH-1:0] done
);

  typedef enum logic [1:0] {IDLE, REQ, XFER, RET} st_t;
  st_t st;

  logic [AW-1:0] base_q [NCH];
  logic [LW-1:0] len_q  [NCH];
  logic [LW-1:0] off_q  [NCH];
  logic [NCH-1:0] circ_q, done_q;
  logic [CW-1:0] sel_q, win;

  logic          pend_v, pend_circ;
  logic [CW-1:0] pend_ch;
  logic [AW-1:0] pend_base;
  logic [LW-1:0] pend_len;

  logic [NCH-1:0] elig;
  logic [LW-1:0]  off_nx;
  logic           idle, apply_cfg, apply_pend;

  assign elig       = chan_req & ~done_q;
  assign idle       = (st == IDLE);
  assign apply_pend = idle && pend_v;
  assign apply_cfg  = idle && !pend_v && cfg_we;
  assign off_nx     = off_q[sel_q] + 1'b1;

  always_comb begin
    win = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (elig[i]) win = CW'(i);
  end

  assign bus_req    = (st == REQ) || (st == XFER);
  assign addr_oe    = (st == XFER);
  assign dev_strobe = addr_oe;
  assign dev_sel    = sel_q;
  assign mem_addr   = addr_oe ? base_q[sel_q] + AW'(off_q[sel_q]) : '0;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      sel_q <= '0;
    end else begin
      case (st)
        IDLE: if (|elig) begin st <= REQ; sel_q <= win; end
        REQ:  if (bus_ack) st <= XFER;
        XFER: st <= RET;
        RET:  if (!bus_ack) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0; pend_ch <= '0; pend_base <= '0; pend_len <= '0; pend_circ <= 1'b0;
    end else if (cfg_we && !apply_cfg) begin
      pend_v <= 1'b1; pend_ch <= cfg_ch; pend_base <= cfg_base;
      pend_len <= cfg_len; pend_circ <= cfg_circ;
    end else if (apply_pend) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        base_q[i] <= '0; len_q[i] <= '0; off_q[i] <= '0;
      end
      circ_q <= '0;
      done_q <= '1;
    end else if (apply_cfg || apply_pend) begin
      base_q[apply_pend ? pend_ch : cfg_ch] <= apply_pend ? pend_base : cfg_base;
      len_q [apply_pend ? pend_ch : cfg_ch] <= apply_pend ? pend_len  : cfg_len;
      circ_q[apply_pend ? pend_ch : cfg_ch] <= apply_pend ? pend_circ : cfg_circ;
      off_q [apply_pend ? pend_ch : cfg_ch] <= '0;
      done_q[apply_pend ? pend_ch : cfg_ch] <= ((apply_pend ? pend_len : cfg_len) == '0);
    end else if (st == XFER) begin
      if (off_nx == len_q[sel_q]) begin
        off_q[sel_q] <= '0;
        if (!circ_q[sel_q]) done_q[sel_q] <= 1'b1;
      end else begin
        off_q[sel_q] <= off_nx;
      end
    end
  end

  // R3
  grant_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe) |-> $past(bus_ack));

  // R5
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |=> !addr_oe && !bus_req);

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe |-> !done[dev_sel]);

  // R3
  req_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> bus_req);

  // R8
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> ($past(elig) & ((NCH'(1) << dev_sel) - NCH'(1))) == '0);

endmodule

// File: tb/dma_addr_ctrl_tb_top.sv
module dma_addr_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_circ = 0, bus_ack = 0;
  logic [2:0] cfg_ch = 0;
  logic [13:0] cfg_base = 0;
  logic [7:0] cfg_len = 0, chan_req = 0;
  logic bus_req, addr_oe, dev_strobe;
  logic [13:0] mem_addr;
  logic [2:0] dev_sel;
  logic [7:0] done;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  dma_addr_ctrl dut_i (.clk, .rst_n, .cfg_we, .cfg_ch, .cfg_base, .cfg_len, .cfg_circ,
    .chan_req, .bus_ack, .bus_req, .addr_oe, .mem_addr, .dev_strobe, .dev_sel, .done);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic prog(input int ch, input int base, input int len, input bit circ);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 3'(ch); cfg_base = 14'(base); cfg_len = 8'(len); cfg_circ = circ;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // one request/grant round; got=0 if no bus request appeared
  task automatic round(input logic [7:0] mask, output bit got, output int ch, output int addr);
    @(negedge clk); chan_req = mask;
    @(negedge clk);
    got = bus_req; ch = 0; addr = 0;
    chan_req = 0;
    if (got) begin
      bus_ack = 1;
      @(negedge clk);
      got = addr_oe && dev_strobe; ch = dev_sel; addr = mem_addr;
      @(negedge clk);
      chk(!bus_req && !addr_oe, "R5 bus returned after one cycle", bus_req, 0);
      bus_ack = 0;
      @(negedge clk);
    end
  endtask

  // {mask, valid, channel, address}
  localparam logic [25:0] VEC [13] = '{
    {8'h02, 1'b1, 3'd1, 14'h3FFE}, {8'h03, 1'b1, 3'd0, 14'h0100},
    {8'h82, 1'b1, 3'd1, 14'h3FFF}, {8'h80, 1'b1, 3'd7, 14'h2000},
    {8'h02, 1'b1, 3'd1, 14'h0000}, {8'h01, 1'b1, 3'd0, 14'h0101},
    {8'h03, 1'b1, 3'd0, 14'h0102}, {8'h03, 1'b1, 3'd1, 14'h0001},
    {8'h01, 1'b0, 3'd0, 14'h0000}, {8'h02, 1'b1, 3'd1, 14'h3FFE},
    {8'h80, 1'b1, 3'd7, 14'h2001}, {8'h80, 1'b1, 3'd7, 14'h2000},
    {8'h00, 1'b0, 3'd0, 14'h0000}};

  initial begin
    repeat (40000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit g; int c, a;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!bus_req && !addr_oe && !dev_strobe, "R1 outputs idle", {bus_req, addr_oe}, 0);
    chk(done == 8'hFF, "R1 done after reset", done, 8'hFF);
    round(8'hFF, g, c, a);
    chk(!g, "R1 unprogrammed channels ignored", g, 0);

    // R2 length zero keeps done
    prog(4, 14'h0055, 0, 0);
    chk(done[4], "R2 zero length stays done", done[4], 1);

    prog(0, 14'h0100, 3, 0);
    prog(1, 14'h3FFE, 4, 1);
    prog(7, 14'h2000, 2, 1);
    chk(done == 8'h7C, "R2 R10 done after programming", done, 8'h7C);

    // R3 R4 R6 R7 R8 vector walk
    for (int i = 0; i < 13; i++) begin
      round(VEC[i][25:18], g, c, a);
      chk(g == VEC[i][17], $sformatf("R3 R8 vec%0d grant", i), g, VEC[i][17]);
      if (VEC[i][17]) begin
        chk(c == VEC[i][16:14], $sformatf("R8 vec%0d channel", i), c, VEC[i][16:14]);
        chk(a == VEC[i][13:0], $sformatf("R4 R7 vec%0d address", i), a, VEC[i][13:0]);
      end
    end
    chk(done == 8'h7D, "R6 R10 one-shot channel done", done, 8'h7D);

    // R6 reprogramming revives channel 0
    prog(0, 14'h0200, 1, 0);
    chk(!done[0], "R6 reprogram clears done", done[0], 0);
    round(8'h01, g, c, a);
    chk(g && a == 14'h0200, "R6 revived channel address", a, 14'h0200);

    // R9 write held off during a grant
    prog(2, 14'h0300, 5, 1);
    @(negedge clk); chan_req = 8'h04;
    @(negedge clk); chan_req = 0;
    chk(bus_req, "R3 request raised", bus_req, 1);
    cfg_we = 1; cfg_ch = 2; cfg_base = 14'h0900; cfg_len = 3; cfg_circ = 1;
    @(negedge clk); cfg_we = 0;
    cfg_ch = 2; cfg_base = 14'h0A00;
    bus_ack = 1;
    @(negedge clk);
    chk(addr_oe && mem_addr == 14'h0300, "R9 old settings during grant", mem_addr, 14'h0300);
    cfg_we = 1;
    @(negedge clk); cfg_we = 0; bus_ack = 0;
    repeat (2) @(negedge clk);
    round(8'h04, g, c, a);
    chk(g && a == 14'h0A00, "R9 later held write applied", a, 14'h0A00);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule